// File: doc/BRIEF.md
# Unlock-Gated Program/Erase Command Sequencer

This block sits between a byte-wide bus front end and the storage of a small flash-style memory. Every destructive operation must be preceded by a fixed unlock pattern: writes of `AAh` to `5555h` and `55h` to `2AAAh`, followed by a command byte. The block recognises byte program, single-block erase, whole-array erase, and entry to and exit from a product-identifier read mode. It also applies two hardware protect inputs. Accepted jobs update a behavioural byte store and occupy the device for a configurable number of clock cycles.

While a job runs, the block raises `busy`. It also replaces read data with status: bit 7 reports completion polarity and bit 6 flips on every read. Storage is split into eight blocks selected by address bits 18:16. To keep the model small, each block stores only `2**OFS_W` bytes, so the offset bits above `OFS_W` alias. Writes and reads are single-cycle strobes. Read data appears one clock after `rd_en` and holds until the next read.

Top module: `sdpseq_top`

## Requirements
- R1: After `AAh@5555h`, `55h@2AAAh`, `A0h@5555h`, the fourth write (address, data) programs the target byte. The new value is the old value ANDed with the data, and the job starts on that fourth write.
- R2: After `AAh@5555h`, `55h@2AAAh`, `80h@5555h`, `AAh@5555h`, `55h@2AAAh`, a sixth write of `30h` or `50h` at any address erases the block chosen by address bits 18:16 to `FFh`. Other blocks are untouched.
- R3: The same five-write prefix followed by `10h@5555h` erases every byte to `FFh`. This happens only when `par_mode` is 1 and both protect inputs are high; otherwise the write is ignored.
- R4: `AAh@5555h`, `55h@2AAAh`, `90h@5555h` enters identifier mode. In that mode address 0 reads `37h`, address 1 reads `DEV_ID`, address 3 reads `7Fh`, and other addresses read `00h`. Identifier mode is left either by the same prefix ending in `F0h@5555h` or by a lone `F0h` written to any address from the idle state.
- R5: A write that does not match the next expected step discards the partial sequence and returns the sequencer to idle, so later steps alone start nothing.
- R6: `busy` rises on the clock edge that accepts a job. It stays high for exactly `PGM_CYC` cycles for a program job and `ERS_CYC` cycles for an erase job.
- R7: A read while busy returns bit 7 equal to the complement of bit 7 of the new programmed value during a program job, and 0 during an erase job. Once `busy` is low, reads return stored data.
- R8: Successive reads while busy return opposite values of bit 6.
- R9: Writes issued while `busy` is high are ignored: they neither advance the sequencer nor change memory.
- R10: With `tbl_n` low, program and block erase of block 7 are rejected. With `wp_n` low, those of blocks 0 to 6 are rejected. The two inputs act independently. A rejected job leaves `busy` low and memory unchanged.
- R11: Synchronous reset clears `busy` and aborts any running job. It also returns the sequencer to idle and leaves identifier mode.
- R12: `rdata` is 0 after reset. It updates one clock after a cycle with `rd_en` high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 19 | Byte address; bits 18:16 select the block |
| wdata | input | 8 | Write data or command byte |
| par_mode | input | 1 | High selects parallel-programming mode (enables chip erase) |
| tbl_n | input | 1 | Low protects the top block (7) |
| wp_n | input | 1 | Low protects blocks 0 to 6 |
| rdata | output | 8 | Registered read data or status |
| busy | output | 1 | High while a program or erase job runs |

## Verification
A sequencer stuck in a wrong state shows up at the next command. A job either starts or fails to start, which is visible on `busy` one edge after the final write, and the stored byte differs on the next read. A wrong job counter shows as `busy` falling one cycle early or late against the exact program and erase windows. A wrong identifier-mode flag corrupts the first read afterwards, because stored data and identifier bytes differ.

// File: rtl/sdpseq_pkg.sv
package sdpseq_pkg;
    localparam int ADDR_W  = 19;
    localparam int BLK_LSB = 16;
    localparam int BLK_W   = ADDR_W - BLK_LSB;
    localparam int N_BLK   = 1 << BLK_W;
    localparam logic [BLK_W-1:0] TOP_BLK = BLK_W'(N_BLK - 1);

    localparam logic [15:0] UNLK_A = 16'h5555;
    localparam logic [15:0] UNLK_B = 16'h2AAA;

    localparam logic [7:0] C_AA    = 8'hAA;
    localparam logic [7:0] C_55    = 8'h55;
    localparam logic [7:0] C_PGM   = 8'hA0;
    localparam logic [7:0] C_ERS   = 8'h80;
    localparam logic [7:0] C_IDIN  = 8'h90;
    localparam logic [7:0] C_EXIT  = 8'hF0;
    localparam logic [7:0] C_BLK1  = 8'h30;
    localparam logic [7:0] C_BLK2  = 8'h50;
    localparam logic [7:0] C_CHIP  = 8'h10;
    localparam logic [7:0] MFR_ID  = 8'h37;
    localparam logic [7:0] CONT_ID = 8'h7F;

    typedef enum logic [2:0] {
        SQ_READ, SQ_U1, SQ_U2, SQ_PGM, SQ_E3, SQ_E4, SQ_E5
    } sq_e;

    typedef enum logic [1:0] {
        JB_PGM, JB_BLK, JB_CHIP
    } jb_e;

    typedef struct packed {
        logic              go;
        jb_e               kind;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } job_t;

    function automatic logic [BLK_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:BLK_LSB];
    endfunction

    function automatic logic blk_locked(input logic [BLK_W-1:0] b,
                                        input logic tbl_n, input logic wp_n);
        return (b == TOP_BLK) ? !tbl_n : !wp_n;
    endfunction
endpackage

// File: rtl/sdpseq_cmd.sv
module sdpseq_cmd
    import sdpseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    input  logic              par_mode,
    input  logic              tbl_n,
    input  logic              wp_n,
    output job_t              job,
    output logic              id_mode
);
    sq_e  st, st_nxt;
    logic id_nxt;
    logic [15:0] a16;
    logic        hit_a, hit_b, locked;

    assign a16    = addr[15:0];
    assign hit_a  = (a16 == UNLK_A);
    assign hit_b  = (a16 == UNLK_B);
    assign locked = blk_locked(blk_of(addr), tbl_n, wp_n);

    always_comb begin
        st_nxt   = st;
        id_nxt   = id_mode;
        job      = '0;
        job.kind = JB_PGM;
        job.addr = addr;
        job.data = wdata;
        if (wr_en && !busy) begin
            st_nxt = SQ_READ;
            case (st)
                SQ_READ: begin
                    if (hit_a && wdata == C_AA)  st_nxt = SQ_U1;
                    else if (wdata == C_EXIT)    id_nxt = 1'b0;
                end
                SQ_U1: if (hit_b && wdata == C_55) st_nxt = SQ_U2;
                SQ_U2: begin
                    if (hit_a) begin
                        case (wdata)
                            C_PGM:   st_nxt = SQ_PGM;
                            C_ERS:   st_nxt = SQ_E3;
                            C_IDIN:  id_nxt = 1'b1;
                            C_EXIT:  id_nxt = 1'b0;
                            default: ;
                        endcase
                    end
                end
                SQ_PGM: begin
                    job.kind = JB_PGM;
                    job.go   = !locked;
                end
                SQ_E3: if (hit_a && wdata == C_AA) st_nxt = SQ_E4;
                SQ_E4: if (hit_b && wdata == C_55) st_nxt = SQ_E5;
                SQ_E5: begin
                    if (wdata == C_BLK1 || wdata == C_BLK2) begin
                        job.kind = JB_BLK;
                        job.go   = !locked;
                    end else if (wdata == C_CHIP && hit_a) begin
                        job.kind = JB_CHIP;
                        job.go   = par_mode && tbl_n && wp_n;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_READ;
            id_mode <= 1'b0;
        end else begin
            st      <= st_nxt;
            id_mode <= id_nxt;
        end
    end

    AST_TOP_LOCK: assert property (@(posedge clk) disable iff (rst)
        (job.go && job.kind != JB_CHIP && blk_of(job.addr) == TOP_BLK) |-> tbl_n); // R10
    AST_LOW_LOCK: assert property (@(posedge clk) disable iff (rst)
        (job.go && job.kind != JB_CHIP && blk_of(job.addr) != TOP_BLK) |-> wp_n); // R10
    AST_CHIP_PAR: assert property (@(posedge clk) disable iff (rst)
        (job.go && job.kind == JB_CHIP) |-> (par_mode && tbl_n && wp_n)); // R3
    AST_SEQ_RESET: assert property (@(posedge clk)
        rst |=> (st == SQ_READ && !id_mode)); // R11
endmodule

// File: rtl/sdpseq_timer.sv
module sdpseq_timer #(
    parameter int PGM_CYC = 200,
    parameter int ERS_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic is_erase,
    output logic busy
);
    localparam int MAXC = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= is_erase ? CW'(ERS_CYC - 1) : CW'(PGM_CYC - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R9
endmodule

// File: rtl/sdpseq_store.sv
module sdpseq_store
    import sdpseq_pkg::*;
#(
    parameter int OFS_W = 6
) (
    input  logic              clk,
    input  job_t              job,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte,
    output logic [7:0]        pgm_new
);
    localparam int DEPTH = 1 << OFS_W;

    logic [7:0] mem [N_BLK][DEPTH];
    logic [BLK_W-1:0] jb, rb;
    logic [OFS_W-1:0] jo, ro;
    logic unused_hi;

    assign jb = blk_of(job.addr);
    assign rb = blk_of(rd_addr);
    assign jo = job.addr[OFS_W-1:0];
    assign ro = rd_addr[OFS_W-1:0];
    assign unused_hi = ^{job.addr[BLK_LSB-1:OFS_W], rd_addr[BLK_LSB-1:OFS_W]};

    assign rd_byte = mem[rb][ro];
    assign pgm_new = mem[jb][jo] & job.data;

    always_ff @(posedge clk) begin
        if (job.go) begin
            case (job.kind)
                JB_PGM: mem[jb][jo] <= pgm_new;
                JB_BLK: for (int o = 0; o < DEPTH; o++) mem[jb][o] <= 8'hFF;
                JB_CHIP: begin
                    for (int b = 0; b < N_BLK; b++)
                        for (int o = 0; o < DEPTH; o++) mem[b][o] <= 8'hFF;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdpseq_top.sv
module sdpseq_top
    import sdpseq_pkg::*;
#(
    parameter int         OFS_W   = 6,
    parameter int         PGM_CYC = 200,
    parameter int         ERS_CYC = 2000,
    parameter logic [7:0] DEV_ID  = 8'h9D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              par_mode,
    input  logic              tbl_n,
    input  logic              wp_n,
    output logic [7:0]        rdata,
    output logic              busy
);
    job_t       job;
    logic       id_mode;
    logic [7:0] rd_byte, pgm_new, id_byte;
    logic [7:0] stat_q;
    logic       erase_q, tgl_q;

    sdpseq_cmd u_cmd (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .par_mode(par_mode), .tbl_n(tbl_n), .wp_n(wp_n),
        .job(job), .id_mode(id_mode)
    );

    sdpseq_timer #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) u_tmr (
        .clk(clk), .rst(rst), .start(job.go),
        .is_erase(job.kind != JB_PGM), .busy(busy)
    );

    sdpseq_store #(.OFS_W(OFS_W)) u_mem (
        .clk(clk), .job(job), .rd_addr(addr),
        .rd_byte(rd_byte), .pgm_new(pgm_new)
    );

    always_comb begin
        case (addr)
            ADDR_W'(0): id_byte = MFR_ID;
            ADDR_W'(1): id_byte = DEV_ID;
            ADDR_W'(3): id_byte = CONT_ID;
            default:    id_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= 8'h00;
            stat_q  <= 8'h00;
            erase_q <= 1'b0;
            tgl_q   <= 1'b0;
        end else begin
            if (job.go) begin
                stat_q  <= pgm_new;
                erase_q <= (job.kind != JB_PGM);
            end
            if (rd_en) begin
                if (busy) begin
                    rdata <= erase_q ? {1'b0, tgl_q, 6'h00}
                                     : {~stat_q[7], tgl_q, stat_q[5:0]};
                    tgl_q <= ~tgl_q;
                end else if (id_mode) begin
                    rdata <= id_byte;
                end else begin
                    rdata <= rd_byte;
                end
            end
        end
    end
endmodule

// File: tb/sim_sdpseq_top.sv
module sim_sdpseq_top;
    localparam int OFS_W = 6;
    localparam int PGM_C = 12;
    localparam int ERS_C = 30;
    localparam logic [7:0] DEVID = 8'h9D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        par_mode = 1'b1, tbl_n = 1'b1, wp_n = 1'b1;
    logic [7:0]  rdata;
    logic        busy;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] ref_mem [8][1 << OFS_W];

    always #4 clk = ~clk;

    sdpseq_top #(.OFS_W(OFS_W), .PGM_CYC(PGM_C), .ERS_CYC(ERS_C), .DEV_ID(DEVID)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .par_mode(par_mode), .tbl_n(tbl_n), .wp_n(wp_n),
        .rdata(rdata), .busy(busy)
    );

    function automatic logic [18:0] mk(input int b, input int o);
        return {3'(b), 16'(o)};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [18:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    task automatic unlk();
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
    endtask

    task automatic prog(input logic [18:0] a, input logic [7:0] d);
        unlk(); wr(19'h05555, 8'hA0); wr(a, d);
    endtask

    task automatic ers6(input logic [18:0] a, input logic [7:0] c);
        unlk(); wr(19'h05555, 8'h80); unlk(); wr(a, c);
    endtask

    function automatic logic [7:0] refrd(input logic [18:0] a);
        return ref_mem[a[18:16]][a[OFS_W-1:0]];
    endfunction

    task automatic ref_blk(input int b);
        for (int o = 0; o < (1 << OFS_W); o++) ref_mem[b][o] = 8'hFF;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2, d, old;
        logic [18:0] a;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11 busy after reset", {7'd0, busy}, 8'h00);
        chk("R12 rdata after reset", rdata, 8'h00);

        // chip erase with exact erase window (R3, R6)
        ers6(19'h05555, 8'h10);
        chk("R6 busy rises", {7'd0, busy}, 8'h01);
        repeat (ERS_C - 1) @(negedge clk);
        chk("R6 busy held erase", {7'd0, busy}, 8'h01);
        @(negedge clk);
        chk("R6 busy falls erase", {7'd0, busy}, 8'h00);
        for (int b = 0; b < 8; b++) ref_blk(b);
        rd(mk(0, 5), v);  chk("R3 chip erased", v, 8'hFF);
        rd(mk(7, 63), v); chk("R3 chip erased top", v, 8'hFF);

        // program status, toggle, window (R1, R6, R7, R8)
        prog(mk(1, 3), 8'h5A);
        ref_mem[1][3] = 8'h5A;
        rd(mk(4, 0), v);
        chk("R7 program poll bit7", {7'd0, v[7]}, 8'h01);
        rd(mk(1, 3), v2);
        chk("R8 toggle", {7'd0, v2[6]}, {7'd0, ~v[6]});
        repeat (PGM_C - 3) @(negedge clk);
        chk("R6 busy held program", {7'd0, busy}, 8'h01);
        @(negedge clk);
        chk("R6 busy falls program", {7'd0, busy}, 8'h00);
        rd(mk(1, 3), v); chk("R7 true data after job", v, 8'h5A);

        // random programming, AND semantics (R1)
        for (int i = 0; i < 40; i++) begin
            a = mk($urandom_range(0, 7), $urandom_range(0, 7));
            d = 8'($urandom);
            old = refrd(a);
            prog(a, d);
            ref_mem[a[18:16]][a[OFS_W-1:0]] = old & d;
            wait_idle();
            rd(a, v);
            chk("R1 program AND", v, old & d);
        end

        // block erase 50h on block 2, status bit7 0 (R2, R7)
        ers6(mk(2, 17), 8'h50);
        rd(mk(2, 0), v);
        chk("R7 erase poll bit7", {7'd0, v[7]}, 8'h00);
        wait_idle();
        ref_blk(2);
        rd(mk(2, 3), v); chk("R2 block erased 50h", v, 8'hFF);
        rd(mk(3, 2), v); chk("R2 other block kept", v, refrd(mk(3, 2)));
        prog(mk(5, 4), 8'h00); wait_idle(); ref_mem[5][4] = 8'h00;
        ers6(mk(5, 9), 8'h30); wait_idle(); ref_blk(5);
        rd(mk(5, 4), v); chk("R2 block erased 30h", v, 8'hFF);

        // chip erase rejected without parallel mode (R3)
        prog(mk(0, 6), 8'h0F); wait_idle(); ref_mem[0][6] = 8'h0F;
        par_mode = 1'b0;
        ers6(19'h05555, 8'h10);
        chk("R3 chip erase rejected busy", {7'd0, busy}, 8'h00);
        rd(mk(0, 6), v); chk("R3 chip erase rejected data", v, 8'h0F);
        par_mode = 1'b1;

        // protection (R10)
        tbl_n = 1'b0;
        old = refrd(mk(7, 1));
        prog(mk(7, 1), 8'h00);
        chk("R10 top locked busy", {7'd0, busy}, 8'h00);
        rd(mk(7, 1), v); chk("R10 top locked data", v, old);
        ers6(mk(7, 0), 8'h30);
        chk("R10 top erase locked", {7'd0, busy}, 8'h00);
        old = refrd(mk(0, 2));
        prog(mk(0, 2), 8'h3C); wait_idle(); ref_mem[0][2] = old & 8'h3C;
        rd(mk(0, 2), v); chk("R10 low blocks free", v, old & 8'h3C);
        tbl_n = 1'b1; wp_n = 1'b0;
        old = refrd(mk(3, 1));
        prog(mk(3, 1), 8'h00);
        chk("R10 low locked busy", {7'd0, busy}, 8'h00);
        rd(mk(3, 1), v); chk("R10 low locked data", v, old);
        old = refrd(mk(7, 2));
        prog(mk(7, 2), 8'h81); wait_idle(); ref_mem[7][2] = old & 8'h81;
        rd(mk(7, 2), v); chk("R10 top free", v, old & 8'h81);
        wp_n = 1'b1;

        // identifier mode (R4)
        unlk(); wr(19'h05555, 8'h90);
        rd(mk(0, 0), v); chk("R4 mfr id", v, 8'h37);
        rd(mk(0, 1), v); chk("R4 dev id", v, DEVID);
        rd(mk(0, 3), v); chk("R4 cont id", v, 8'h7F);
        rd(mk(0, 2), v); chk("R4 other id", v, 8'h00);
        wr(mk(4, 9), 8'hF0);
        rd(mk(0, 1), v); chk("R4 lone exit", v, refrd(mk(0, 1)));
        unlk(); wr(19'h05555, 8'h90);
        rd(mk(0, 0), v); chk("R4 re-entry", v, 8'h37);
        unlk(); wr(19'h05555, 8'hF0);
        rd(mk(0, 0), v); chk("R4 prefix exit", v, refrd(mk(0, 0)));

        // broken sequences (R5)
        old = refrd(mk(6, 5));
        unlk(); wr(19'h05555, 8'h77); wr(19'h05555, 8'hA0); wr(mk(6, 5), 8'h00);
        chk("R5 bad command busy", {7'd0, busy}, 8'h00);
        wr(19'h05555, 8'hAA); wr(19'h01234, 8'h55); wr(19'h05555, 8'hA0); wr(mk(6, 5), 8'h00);
        chk("R5 bad address busy", {7'd0, busy}, 8'h00);
        rd(mk(6, 5), v); chk("R5 data kept", v, old);

        // writes during busy ignored (R9)
        old = refrd(mk(4, 7));
        prog(mk(2, 1), 8'hC3); ref_mem[2][1] = 8'hFF & 8'hC3;
        prog(mk(4, 7), 8'h00);
        wait_idle();
        chk("R9 no second job", {7'd0, busy}, 8'h00);
        rd(mk(4, 7), v); chk("R9 write ignored", v, old);
        rd(mk(2, 1), v); chk("R9 first job done", v, 8'hC3);

        // read hold (R12)
        repeat (5) @(negedge clk);
        chk("R12 rdata holds", rdata, 8'hC3);

        // reset abort (R11)
        ers6(mk(6, 0), 8'h30);
        repeat (3) @(negedge clk);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R11 abort clears busy", {7'd0, busy}, 8'h00);
        unlk(); wr(19'h05555, 8'h90);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        rd(mk(0, 1), v); chk("R11 leaves id mode", v, refrd(mk(0, 1)));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule